// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Controller

This block is the read-side sequencer of a 16-bit memory. A configuration register chooses between plain single-word reads, which are the mode after reset, and clocked burst reads. For burst reads the register also sets the first-access latency, the number of clocks each word is held, the burst order, the burst length, when WAIT# is signalled, and the clock edge on which outputs change. The address-valid strobe `adv_n` latches the start address and restarts the sequencer. The block then walks the burst addresses on a combinational array read port and returns each word on registered outputs.

Continuous bursts count upward linearly. The first time such a burst crosses a sixteen-word boundary, the block inserts a single stall. The stall length depends on where the start address sits within its four-word group. WAIT# reports the stall, either in the stall cycles only or from one clock earlier. Addresses in a low region hold parameter and identifier data and always return one word.

Top module: `burst_read_ctrl`

## Requirements
- R1: During and after reset, `dout_valid` is 0 and `wait_n` is 1. The configuration register resets to zero, which selects single-word mode.
- R2: A clock edge with `cfg_wr` high loads `cfg_data` into the configuration register. The fields are:
  - bit 15: burst mode (1) or single-word mode (0).
  - bits 13:11: latency L. Values below 2 act as 2.
  - bit 9: hold each word two clocks.
  - bit 8: early WAIT#.
  - bit 7: interleaved order.
  - bit 6: falling-edge outputs.
  - bits 2:0: length. 001 selects four words, 010 eight words, 111 continuous, and any other code four words.
- R3: In single-word mode, `adv_n` low at edge 0 makes `dout_valid` high for the single cycle after edge 1. `dout` then equals the array word at `addr_in`.
- R4: In burst mode, the first word is valid in the cycle after edge L, where edge 0 samples `adv_n` low.
- R5: Linear four- and eight-word bursts increment the low 2 or 3 address bits and wrap within the aligned group.
- R6: Interleaved four- and eight-word bursts use, for word j, the start address with j XORed into its low 2 or 3 bits.
- R7: With two-clock hold, each word stays valid and unchanged for two consecutive cycles. With one-clock hold, each word lasts one cycle.
- R8: Continuous bursts use start+j for word j regardless of the interleave bit. They end after address all-ones, and `dout_valid` then falls.
- R9: The first time a continuous burst reaches an address whose low four bits are zero (not the start word), it stalls for floor(k*L/3) cycles with `dout_valid` low, where k is start[1:0]. Later sixteen-word boundaries cause no stall.
- R10: `wait_n` is 0 in every stall cycle and 1 otherwise. With early WAIT# it is also 0 in the last valid cycle before the stall.
- R11: With falling-edge outputs, `dout`, `dout_valid` and `wait_n` change at the falling edge. Each value therefore appears half a clock later than in rising mode.
- R12: Start addresses below PARAM_WORDS return a single word even in burst mode.
- R13: `adv_n` low during an active burst abandons it and starts a new access with the timing of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration register write enable |
| cfg_data | input | 16 | Configuration value |
| adv_n | input | 1 | Address-valid strobe, active low |
| addr_in | input | AW | Start address |
| arr_addr | output | AW | Array read address |
| arr_data | input | DW | Array read data (combinational) |
| dout | output | DW | Output data word |
| dout_valid | output | 1 | Output word valid |
| wait_n | output | 1 | Stall indication, active low |

## Verification
With early WAIT#, the stall warning and a valid data word fall in the same cycle. In that cycle `wait_n` is low while `dout_valid` is high and the last word before the boundary is on `dout`. The bench provokes this with a continuous burst that starts one word past a four-word boundary, so the stall is short but non-zero. It compares every sampled cycle against a trace built from the requirements. A second coincidence is a new strobe arriving while a burst is streaming. The bench judges this by requiring the fresh access to follow exactly the first-word timing, with no trace of the abandoned burst.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA, ST_STALL} brc_state_e;
  typedef enum logic [1:0] {BM_FOUR, BM_EIGHT, BM_CONT, BM_SINGLE} brc_mode_e;

  typedef struct packed {
    logic       sync;
    logic [2:0] lat;
    logic       hold2;
    logic       early;
    logic       inter;
    logic       fall;
    logic [2:0] len;
  } brc_cfg_t;

  function automatic brc_cfg_t brc_decode(input logic [15:0] raw);
    brc_cfg_t c;
    c.sync  = raw[15];
    c.lat   = raw[13:11];
    c.hold2 = raw[9];
    c.early = raw[8];
    c.inter = raw[7];
    c.fall  = raw[6];
    c.len   = raw[2:0];
    return c;
  endfunction

  function automatic logic [2:0] brc_lat_eff(input logic [2:0] f);
    return (f < 3'd2) ? 3'd2 : f;
  endfunction

  // stall = floor(offset * latency / 3)
  function automatic logic [4:0] brc_stall_len(input logic [1:0] k, input logic [2:0] lat);
    logic [4:0] p;
    p = 5'(k) * 5'(lat);
    return p / 5'd3;
  endfunction

endpackage

// File: rtl/brc_addr_gen.sv
module brc_addr_gen
  import brc_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0] base,
  input  logic [AW:0]   beat,
  input  brc_mode_e     mode,
  input  logic          inter,
  output logic [AW-1:0] addr,
  output logic          past_end
);
  logic [AW:0] sum;
  logic [1:0]  lo2;
  logic [2:0]  lo3;

  always_comb begin
    sum      = {1'b0, base} + beat;
    lo2      = inter ? (base[1:0] ^ beat[1:0]) : (base[1:0] + beat[1:0]);
    lo3      = inter ? (base[2:0] ^ beat[2:0]) : (base[2:0] + beat[2:0]);
    past_end = 1'b0;
    case (mode)
      BM_FOUR:  addr = {base[AW-1:2], lo2};
      BM_EIGHT: addr = {base[AW-1:3], lo3};
      BM_CONT: begin
        addr     = sum[AW-1:0];
        past_end = sum[AW];
      end
      default:  addr = base;
    endcase
  end
endmodule

// File: rtl/brc_seq.sv
module brc_seq
  import brc_pkg::*;
#(
  parameter int AW          = 12,
  parameter int DW          = 16,
  parameter int PARAM_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  brc_cfg_t      cfg,
  input  logic          adv_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] r_dout,
  output logic          r_valid,
  output logic          r_wait_n,
  output brc_mode_e     mode_o,
  output logic          hold2_o,
  output logic          early_o
);
  localparam int BW = AW + 1;

  brc_state_e    st, st_n;
  brc_mode_e     mode, mode_n;
  logic [AW-1:0] base, base_n;
  logic [BW-1:0] beat, beat_n, nbeats;
  logic          hc, hc_n;
  logic [2:0]    lat_c, lat_c_n, lat_q, lat_q_n;
  logic [4:0]    sc, sc_n, s_len, s_len_n;
  logic          stalled, stalled_n;
  logic          inter, inter_n, hold2, hold2_n, early, early_n;
  logic          load, done, stall_now, due_n, hold_last, hold_last_n;
  logic [AW-1:0] cur_addr, nxt_addr;
  logic          cur_end, nxt_end;

  brc_addr_gen #(.AW(AW)) u_cur (
    .base(base), .beat(beat), .mode(mode), .inter(inter),
    .addr(cur_addr), .past_end(cur_end)
  );

  brc_addr_gen #(.AW(AW)) u_nxt (
    .base(base_n), .beat(beat_n), .mode(mode_n), .inter(inter_n),
    .addr(nxt_addr), .past_end(nxt_end)
  );

  assign arr_addr = cur_addr;
  assign mode_o   = mode;
  assign hold2_o  = hold2;
  assign early_o  = early;

  always_comb begin
    case (mode)
      BM_FOUR:  nbeats = BW'(4);
      BM_EIGHT: nbeats = BW'(8);
      default:  nbeats = BW'(1);
    endcase
    s_len     = brc_stall_len(base[1:0], lat_q);
    done      = (mode == BM_CONT) ? cur_end : (beat == nbeats);
    hold_last = !hold2 || hc;
    stall_now = (mode == BM_CONT) && !stalled && (beat != '0) &&
                (cur_addr[3:0] == 4'd0) && (s_len != 5'd0) && !cur_end;

    st_n = st; mode_n = mode; base_n = base; beat_n = beat; hc_n = hc;
    lat_c_n = lat_c; lat_q_n = lat_q; sc_n = sc; stalled_n = stalled;
    inter_n = inter; hold2_n = hold2; early_n = early; load = 1'b0;

    if (!adv_n) begin
      st_n      = ST_LAT;
      base_n    = addr_in;
      beat_n    = '0;
      hc_n      = 1'b0;
      stalled_n = 1'b0;
      if (!cfg.sync || (addr_in < AW'(PARAM_WORDS))) mode_n = BM_SINGLE;
      else if (cfg.len == 3'b001)                    mode_n = BM_FOUR;
      else if (cfg.len == 3'b010)                    mode_n = BM_EIGHT;
      else if (cfg.len == 3'b111)                    mode_n = BM_CONT;
      else                                           mode_n = BM_FOUR;
      inter_n = cfg.inter && (mode_n != BM_CONT);
      hold2_n = cfg.hold2 && cfg.sync;
      early_n = cfg.early;
      lat_q_n = brc_lat_eff(cfg.lat);
      lat_c_n = cfg.sync ? brc_lat_eff(cfg.lat) : 3'd1;
    end else begin
      case (st)
        ST_LAT: begin
          if (lat_c == 3'd1) begin
            load = 1'b1; st_n = ST_DATA; beat_n = beat + 1'b1; hc_n = 1'b0;
          end else begin
            lat_c_n = lat_c - 3'd1;
          end
        end
        ST_DATA: begin
          if (!hold_last) begin
            hc_n = 1'b1;
          end else if (done) begin
            st_n = ST_IDLE;
          end else if (stall_now) begin
            st_n = ST_STALL; sc_n = s_len; stalled_n = 1'b1;
          end else begin
            load = 1'b1; beat_n = beat + 1'b1; hc_n = 1'b0;
          end
        end
        ST_STALL: begin
          if (sc == 5'd1) begin
            load = 1'b1; st_n = ST_DATA; beat_n = beat + 1'b1; hc_n = 1'b0;
          end else begin
            sc_n = sc - 5'd1;
          end
        end
        default: ;
      endcase
    end

    s_len_n     = brc_stall_len(base_n[1:0], lat_q_n);
    hold_last_n = !hold2_n || hc_n;
    due_n       = (mode_n == BM_CONT) && !stalled_n && (beat_n != '0) &&
                  (nxt_addr[3:0] == 4'd0) && (s_len_n != 5'd0) && !nxt_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; mode <= BM_SINGLE; base <= '0; beat <= '0; hc <= 1'b0;
      lat_c <= 3'd0; lat_q <= 3'd2; sc <= 5'd0; stalled <= 1'b0;
      inter <= 1'b0; hold2 <= 1'b0; early <= 1'b0;
      r_dout <= '0; r_valid <= 1'b0; r_wait_n <= 1'b1;
    end else begin
      st <= st_n; mode <= mode_n; base <= base_n; beat <= beat_n; hc <= hc_n;
      lat_c <= lat_c_n; lat_q <= lat_q_n; sc <= sc_n; stalled <= stalled_n;
      inter <= inter_n; hold2 <= hold2_n; early <= early_n;
      if (load) r_dout <= arr_data;
      r_valid  <= (st_n == ST_DATA);
      r_wait_n <= !((st_n == ST_STALL) ||
                    (early_n && (st_n == ST_DATA) && hold_last_n && due_n));
    end
  end
endmodule

// File: rtl/brc_edge_out.sv
module brc_edge_out #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall_sel,
  input  logic [DW-1:0] r_dout,
  input  logic          r_valid,
  input  logic          r_wait_n,
  output logic [DW-1:0] out_dout,
  output logic          out_valid,
  output logic          out_wait_n,
  output logic          f_valid_o
);
  logic [DW-1:0] f_dout;
  logic          f_valid, f_wait_n;

  always_ff @(negedge clk) begin
    if (rst) begin
      f_dout <= '0; f_valid <= 1'b0; f_wait_n <= 1'b1;
    end else begin
      f_dout <= r_dout; f_valid <= r_valid; f_wait_n <= r_wait_n;
    end
  end

  assign out_dout   = fall_sel ? f_dout   : r_dout;
  assign out_valid  = fall_sel ? f_valid  : r_valid;
  assign out_wait_n = fall_sel ? f_wait_n : r_wait_n;
  assign f_valid_o  = f_valid;
endmodule

// File: rtl/burst_read_ctrl.sv
module burst_read_ctrl
  import brc_pkg::*;
#(
  parameter int AW          = 12,
  parameter int DW          = 16,
  parameter int PARAM_WORDS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [15:0]   cfg_data,
  input  logic          adv_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] dout,
  output logic          dout_valid,
  output logic          wait_n
);
  logic [15:0]   cfg_q;
  brc_cfg_t      cfg;
  logic [DW-1:0] seq_dout;
  logic          seq_valid, seq_wait_n, fall_valid;
  brc_mode_e     seq_mode;
  logic          seq_hold2, seq_early;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= 16'h0000;
    else if (cfg_wr) cfg_q <= cfg_data;
  end

  assign cfg = brc_decode(cfg_q);

  brc_seq #(.AW(AW), .DW(DW), .PARAM_WORDS(PARAM_WORDS)) u_seq (
    .clk(clk), .rst(rst), .cfg(cfg), .adv_n(adv_n), .addr_in(addr_in),
    .arr_addr(arr_addr), .arr_data(arr_data),
    .r_dout(seq_dout), .r_valid(seq_valid), .r_wait_n(seq_wait_n),
    .mode_o(seq_mode), .hold2_o(seq_hold2), .early_o(seq_early)
  );

  brc_edge_out #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .fall_sel(cfg.fall),
    .r_dout(seq_dout), .r_valid(seq_valid), .r_wait_n(seq_wait_n),
    .out_dout(dout), .out_valid(dout_valid), .out_wait_n(wait_n),
    .f_valid_o(fall_valid)
  );
endmodule

// File: rtl/burst_read_ctrl_chk.sv
module burst_read_ctrl_chk
  import brc_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          adv_n,
  input logic [DW-1:0] r_dout,
  input logic          r_valid,
  input logic          r_wait_n,
  input logic          f_valid,
  input brc_mode_e     mode_q,
  input logic          hold2_q,
  input logic          early_q
);
  AST_SINGLE_ONE_BEAT: assert property (@(posedge clk) disable iff (rst)
    (mode_q == BM_SINGLE && r_valid && !hold2_q && adv_n) |=> !r_valid); // R12
  AST_HOLD_TWO: assert property (@(posedge clk) disable iff (rst)
    (hold2_q && $rose(r_valid) && adv_n) |=> (r_valid && $stable(r_dout))); // R7
  AST_LATE_WAIT_GAP: assert property (@(posedge clk) disable iff (rst)
    (!r_wait_n && !early_q) |-> !r_valid); // R10
  AST_WAIT_CONT_ONLY: assert property (@(posedge clk) disable iff (rst)
    !r_wait_n |-> (mode_q == BM_CONT)); // R9
  AST_FALL_COPY: assert property (@(posedge clk) disable iff (rst)
    f_valid == r_valid); // R11
endmodule

bind burst_read_ctrl burst_read_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .adv_n(adv_n),
  .r_dout(seq_dout), .r_valid(seq_valid), .r_wait_n(seq_wait_n),
  .f_valid(fall_valid), .mode_q(seq_mode), .hold2_q(seq_hold2), .early_q(seq_early)
);

// File: tb/burst_read_ctrl_tb.sv
module burst_read_ctrl_tb;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NMAX = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic [15:0]   cfg_data = '0;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_data;
  logic [DW-1:0] dout;
  logic          dout_valid, wait_n;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic          exp_v [NMAX];
  logic          exp_w [NMAX];
  logic [DW-1:0] exp_d [NMAX];

  always #5 clk = ~clk;

  assign arr_data = {4'hA, arr_addr};

  burst_read_ctrl #(.AW(AW), .DW(DW), .PARAM_WORDS(16)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .adv_n(adv_n), .addr_in(addr_in), .arr_addr(arr_addr), .arr_data(arr_data),
    .dout(dout), .dout_valid(dout_valid), .wait_n(wait_n)
  );

  function automatic logic [15:0] mk_cfg(bit sync, int lat, bit hold2, bit early,
                                         bit inter, bit fall, logic [2:0] len);
    logic [15:0] c;
    c = '0;
    c[15] = sync; c[13:11] = 3'(lat); c[9] = hold2; c[8] = early;
    c[7] = inter; c[6] = fall; c[2:0] = len;
    return c;
  endfunction

  // ln: 0 four, 1 eight, 2 continuous, 3 single
  function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] s, int j, int ln, bit it);
    logic [AW-1:0] a;
    logic [2:0] jj;
    jj = 3'(j);
    a = s;
    case (ln)
      0: a[1:0] = it ? (s[1:0] ^ jj[1:0]) : (s[1:0] + jj[1:0]);
      1: a[2:0] = it ? (s[2:0] ^ jj) : (s[2:0] + jj);
      2: a = s + AW'(j);
      default: a = s;
    endcase
    return a;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; adv_n = 1'b1; cfg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_cfg(logic [15:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_data = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic build_exp(logic [AW-1:0] s, bit sync, int lat, int hold, int ln,
                           bit it, bit early, int lag);
    int pos, nw, k, sl, idx;
    bit stalled;
    logic [AW-1:0] a;
    for (int i = 0; i < NMAX; i++) begin
      exp_v[i] = 1'b0; exp_w[i] = 1'b1; exp_d[i] = '0;
    end
    if (!sync) begin lat = 1; hold = 1; end
    if (!sync || s < 16) ln = 3;
    if (ln == 2) it = 0;
    if (lat < 2 && sync) lat = 2;
    k  = int'(s[1:0]);
    sl = (k * lat) / 3;
    nw = (ln == 3) ? 1 : (ln == 0) ? 4 : (ln == 1) ? 8 : (4096 - int'(s));
    pos = lat;
    stalled = 0;
    for (int j = 0; j < nw && pos < NMAX; j++) begin
      a = exp_addr(s, j, ln, it);
      if (ln == 2 && !stalled && j > 0 && a[3:0] == 4'd0 && sl > 0) begin
        stalled = 1;
        if (early && pos - 1 + lag < NMAX) exp_w[pos - 1 + lag] = 1'b0;
        for (int t = 0; t < sl; t++) begin
          idx = pos + t + lag;
          if (idx < NMAX) exp_w[idx] = 1'b0;
        end
        pos += sl;
      end
      for (int h = 0; h < hold; h++) begin
        idx = pos + lag;
        if (idx < NMAX) begin exp_v[idx] = 1'b1; exp_d[idx] = {4'hA, a}; end
        pos++;
      end
    end
  endtask

  // Strobe at edge 0, sample after edges 0..n-1 and compare with the model.
  task automatic run_burst(logic [AW-1:0] s, int n, bit sync, int lat, int hold,
                           int ln, bit it, bit early, int lag, string req);
    bit ok;
    build_exp(s, sync, lat, hold, ln, it, early, lag);
    @(negedge clk); adv_n = 1'b0; addr_in = s;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #3;
      if (k == 0) adv_n = 1'b1;
      if (k >= lag) begin
        ok = (dout_valid === exp_v[k]) && (wait_n === exp_w[k]) &&
             (!exp_v[k] || dout === exp_d[k]);
        checks++;
        if (!ok) begin
          errors++;
          $display("FAIL %s start=%h cycle %0d: valid=%b wait_n=%b dout=%h expected valid=%b wait_n=%b dout=%h",
                   req, s, k, dout_valid, wait_n, dout, exp_v[k], exp_w[k], exp_d[k]);
        end
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(posedge clk); #3;
    checks++;
    if (dout_valid !== 1'b0 || wait_n !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: valid=%b wait_n=%b expected valid=0 wait_n=1", dout_valid, wait_n);
    end
  endtask

  task automatic t_async();        // R1 R3: reset value selects single-word reads
    do_reset();
    run_burst(12'h123, 5, 0, 0, 1, 3, 0, 0, 0, "R3");
  endtask

  task automatic t_linear4();      // R2 R4 R5
    do_reset(); write_cfg(mk_cfg(1, 3, 0, 0, 0, 0, 3'b001));
    run_burst(12'h106, 10, 1, 3, 1, 0, 0, 0, 0, "R5");
  endtask

  task automatic t_inter8();       // R6
    do_reset(); write_cfg(mk_cfg(1, 4, 0, 0, 1, 0, 3'b010));
    run_burst(12'h20B, 16, 1, 4, 1, 1, 1, 0, 0, "R6");
  endtask

  task automatic t_hold2();        // R7
    do_reset(); write_cfg(mk_cfg(1, 2, 1, 0, 0, 0, 3'b001));
    run_burst(12'h300, 12, 1, 2, 2, 0, 0, 0, 0, "R7");
  endtask

  task automatic t_cont_worst();   // R8 R9 R10: offset 3, late WAIT#, interleave bit ignored
    do_reset(); write_cfg(mk_cfg(1, 6, 0, 0, 1, 0, 3'b111));
    run_burst(12'h40B, 30, 1, 6, 1, 2, 1, 0, 0, "R9");
  endtask

  task automatic t_cont_early();   // R9 R10: offset 1, early WAIT#, second boundary no stall
    do_reset(); write_cfg(mk_cfg(1, 6, 0, 1, 0, 0, 3'b111));
    run_burst(12'h50D, 32, 1, 6, 1, 2, 0, 1, 0, "R10");
  endtask

  task automatic t_cont_aligned(); // R9: aligned start never stalls
    do_reset(); write_cfg(mk_cfg(1, 5, 0, 1, 0, 0, 3'b111));
    run_burst(12'h604, 24, 1, 5, 1, 2, 0, 1, 0, "R9");
  endtask

  task automatic t_cont_end();     // R8: stops after the top address
    do_reset(); write_cfg(mk_cfg(1, 2, 0, 0, 0, 0, 3'b111));
    run_burst(12'hFFD, 10, 1, 2, 1, 2, 0, 0, 0, "R8");
  endtask

  task automatic t_single_region(); // R12
    do_reset(); write_cfg(mk_cfg(1, 3, 0, 0, 0, 0, 3'b010));
    run_burst(12'h005, 8, 1, 3, 1, 1, 0, 0, 0, "R12");
  endtask

  task automatic t_falling();      // R11
    do_reset(); write_cfg(mk_cfg(1, 2, 0, 0, 0, 1, 3'b001));
    run_burst(12'h700, 9, 1, 2, 1, 0, 0, 0, 1, "R11");
  endtask

  task automatic t_restart();      // R13, and R2 latency code 0 acting as 2
    do_reset(); write_cfg(mk_cfg(1, 0, 0, 0, 0, 0, 3'b010));
    @(negedge clk); adv_n = 1'b0; addr_in = 12'h800;
    @(negedge clk); adv_n = 1'b1;
    repeat (4) @(negedge clk);
    run_burst(12'h935, 12, 1, 2, 1, 1, 0, 0, 0, "R13");
  endtask

  initial begin
    t_reset();
    t_async();
    t_linear4();
    t_inter8();
    t_hold2();
    t_cont_worst();
    t_cont_early();
    t_cont_aligned();
    t_cont_end();
    t_single_region();
    t_falling();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule